// File: doc/BRIEF.md
# ADC Result Interrupt Flag Unit

This block keeps the interrupt bookkeeping for an eight-input analog-to-digital converter. The conversion sequencer pulses one result-load strobe per analog input whenever it writes a fresh result for that input. For every input the block holds a completion flag and an overwrite-error flag. The overwrite-error flag records that a result arrived while the previous completion had not yet been acknowledged. Each flag has its own enable bit. The enabled flags are merged into a single registered interrupt request for the system interrupt controller.

Software reaches the flags and enables through a small register port. Flags are acknowledged by writing ones to them. The block never pushes back on the sequencer: every strobe is taken in the cycle it arrives. A small request state machine with two states, `IRQ_IDLE` and `IRQ_ACTIVE`, drives the request. It takes transition *raise* (`IRQ_IDLE` to `IRQ_ACTIVE`) when any enabled flag is set. It takes transition *drop* (`IRQ_ACTIVE` to `IRQ_IDLE`) when none is set. In all other cases it holds its state.

Top module: `adc_irq_flags`

## Requirements
- R1: Reset (`rst_n` low) clears all completion flags, overwrite flags and enable bits, and drives `irq` low.
- R2: A high `load_stb[m]` sampled at a clock edge leaves completion flag m set after that edge. Completion flags read at register address 0, with bit m for input m.
- R3: A high `load_stb[m]` sampled while completion flag m already holds 1 sets overwrite flag m, read at address 1 with bit m for input m. The value of flag m before that edge decides, even when a clear hits it in the same cycle. Selecting any address for reading has no effect on this decision.
- R4: A write (`reg_wr` high) to address 0 or 1 clears each flag whose `reg_wdata` bit is 1. Flags whose data bit is 0 keep their value.
- R5: When a load strobe and a write-1 clear hit the same completion flag in one cycle, the flag ends up 1.
- R6: Completion enables live at address 2 and overwrite enables at address 3, with bit m for input m. A write stores `reg_wdata`, and a read returns the stored value.
- R7: `irq` goes high one clock after any flag is 1 together with its enable bit. It goes low one clock after the last such pair goes away. It stays low while flags are set but not enabled.
- R8: Strobes on several inputs in one cycle each update their own input's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 8 | Result-load strobe, one bit per analog input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 completion flags, 1 overwrite flags, 2 completion enables, 3 overwrite enables |
| reg_wdata | input | 8 | Write data, bit m for input m |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag that is stuck, or that misses a set or a clear, shows on `reg_rdata` as soon as its address is selected, in the same cycle after the faulty edge. With the matching enable set, it also appears on `irq` one clock later. An enable register that holds the wrong value shows on readback at once. Its effect on `irq` shows one clock later, because the request is registered. Same-cycle races between load and clear are the corner case most likely to hide a wrong internal state. For that reason both flag registers are read back after every stimulus vector.

// File: rtl/adcirq_pkg.sv
package adcirq_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CMP_FLAGS = 2'd0,
        SEL_OVR_FLAGS = 2'd1,
        SEL_CMP_EN    = 2'd2,
        SEL_OVR_EN    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/adcirq_flag_cell.sv
module adcirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cmp_clr,
    input  logic ovr_clr,
    output logic cmp_flag,
    output logic ovr_flag
);

    logic cmp_q;
    logic ovr_q;
    logic cmp_d;
    logic ovr_d;

    // A load always wins over an acknowledge of the same flag.
    // The overwrite decision uses the completion value held before this edge.
    always_comb begin
        cmp_d = load | (cmp_q & ~cmp_clr);
        ovr_d = (load & cmp_q) | (ovr_q & ~ovr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            cmp_q <= cmp_d;
            ovr_q <= ovr_d;
        end
    end

    assign cmp_flag = cmp_q;
    assign ovr_flag = ovr_q;

endmodule

// File: rtl/adcirq_regbank.sv
module adcirq_regbank
    import adcirq_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [N_IN-1:0]       reg_wdata,
    input  logic [N_IN-1:0]       cmp_flags,
    input  logic [N_IN-1:0]       ovr_flags,
    output logic [N_IN-1:0]       cmp_clr,
    output logic [N_IN-1:0]       ovr_clr,
    output logic [N_IN-1:0]       cmp_en,
    output logic [N_IN-1:0]       ovr_en,
    output logic [N_IN-1:0]       reg_rdata
);

    reg_sel_e        sel;
    logic [N_IN-1:0] cmp_en_q;
    logic [N_IN-1:0] ovr_en_q;

    assign sel = reg_sel_e'(reg_addr);

    // Write-one-to-clear masks toward the flag cells.
    always_comb begin
        cmp_clr = '0;
        ovr_clr = '0;
        if (reg_wr) begin
            unique case (sel)
                SEL_CMP_FLAGS: cmp_clr = reg_wdata;
                SEL_OVR_FLAGS: ovr_clr = reg_wdata;
                SEL_CMP_EN,
                SEL_OVR_EN:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_en_q <= '0;
            ovr_en_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_CMP_EN) cmp_en_q <= reg_wdata;
            if (sel == SEL_OVR_EN) ovr_en_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CMP_FLAGS: reg_rdata = cmp_flags;
            SEL_OVR_FLAGS: reg_rdata = ovr_flags;
            SEL_CMP_EN:    reg_rdata = cmp_en_q;
            SEL_OVR_EN:    reg_rdata = ovr_en_q;
        endcase
    end

    assign cmp_en = cmp_en_q;
    assign ovr_en = ovr_en_q;

endmodule

// File: rtl/adcirq_req_fsm.sv
module adcirq_req_fsm
    import adcirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE;  // raise
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;    // drop
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   irq = 1'b0;
            IRQ_ACTIVE: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags
    import adcirq_pkg::*;
#(
    parameter int unsigned N_IN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN-1:0]       load_stb,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [N_IN-1:0]       reg_wdata,
    output logic [N_IN-1:0]       reg_rdata,
    output logic                  irq
);

    logic [N_IN-1:0] cmp_flags;
    logic [N_IN-1:0] ovr_flags;
    logic [N_IN-1:0] cmp_clr;
    logic [N_IN-1:0] ovr_clr;
    logic [N_IN-1:0] cmp_en;
    logic [N_IN-1:0] ovr_en;
    logic            pending;

    for (genvar g = 0; g < N_IN; g++) begin : g_cell
        adcirq_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_stb[g]),
            .cmp_clr  (cmp_clr[g]),
            .ovr_clr  (ovr_clr[g]),
            .cmp_flag (cmp_flags[g]),
            .ovr_flag (ovr_flags[g])
        );
    end

    adcirq_regbank #(.N_IN(N_IN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmp_flags (cmp_flags),
        .ovr_flags (ovr_flags),
        .cmp_clr   (cmp_clr),
        .ovr_clr   (ovr_clr),
        .cmp_en    (cmp_en),
        .ovr_en    (ovr_en),
        .reg_rdata (reg_rdata)
    );

    assign pending = |((cmp_flags & cmp_en) | (ovr_flags & ovr_en));

    adcirq_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq)
    );

endmodule

// File: rtl/adc_irq_flags_chk.sv
module adc_irq_flags_chk #(
    parameter int unsigned N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] load_stb,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic [N_IN-1:0] reg_wdata,
    input logic [N_IN-1:0] cmp_flags,
    input logic [N_IN-1:0] ovr_flags,
    input logic [N_IN-1:0] cmp_en,
    input logic [N_IN-1:0] ovr_en,
    input logic            irq
);

    logic [N_IN-1:0] cmp_ack;
    logic [N_IN-1:0] ovr_ack;
    logic [N_IN-1:0] hit;
    logic            any_enabled;

    assign cmp_ack     = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;
    assign ovr_ack     = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
    assign hit         = load_stb & cmp_flags;
    assign any_enabled = |((cmp_flags & cmp_en) | (ovr_flags & ovr_en));

    // R2
    load_sets_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != '0) |=> ((cmp_flags & $past(load_stb)) == $past(load_stb)));

    // R3
    overwrite_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((ovr_flags & $past(hit)) == $past(hit)));

    // R4
    cmp_falls_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flags != '0) |=> ((($past(cmp_flags) & ~cmp_flags) & ~$past(cmp_ack)) == '0));

    // R4
    ovr_falls_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flags != '0) |=> ((($past(ovr_flags) & ~ovr_flags) & ~$past(ovr_ack)) == '0));

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_enabled |=> irq);

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_enabled |=> !irq);

endmodule

bind adc_irq_flags adc_irq_flags_chk #(.N_IN(N_IN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cmp_flags (cmp_flags),
    .ovr_flags (ovr_flags),
    .cmp_en    (cmp_en),
    .ovr_en    (ovr_en),
    .irq       (irq)
);

// File: tb/test_adc_irq_flags.sv
module test_adc_irq_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] load_stb = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_irq_flags i_adc_irq_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_stb  (load_stb),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Vector: {load[34:27], wr[26], addr[25:24], wdata[23:16], exp_cmp[15:8], exp_ovr[7:0]}
    localparam int NV = 11;
    localparam logic [34:0] VEC [NV] = '{
        {8'h01, 1'b0, 2'd0, 8'h00, 8'h01, 8'h00},  // R2 first result on input 0
        {8'h03, 1'b0, 2'd0, 8'h00, 8'h03, 8'h01},  // R3 R8 input 0 overwritten, input 1 fresh
        {8'h00, 1'b1, 2'd0, 8'h00, 8'h03, 8'h01},  // R4 writing zeros changes nothing
        {8'h00, 1'b1, 2'd0, 8'h01, 8'h02, 8'h01},  // R4 acknowledge completion 0
        {8'h00, 1'b1, 2'd1, 8'h01, 8'h02, 8'h00},  // R4 acknowledge overwrite 0
        {8'h82, 1'b1, 2'd0, 8'h02, 8'h82, 8'h02},  // R5 load beats ack on input 1
        {8'h80, 1'b1, 2'd1, 8'h02, 8'h82, 8'h80},  // R3 R4 overwrite 7, ack overwrite 1
        {8'h00, 1'b1, 2'd0, 8'hFF, 8'h00, 8'h80},  // R4 ack all completions
        {8'h00, 1'b1, 2'd1, 8'hFF, 8'h00, 8'h00},  // R4 ack all overwrites
        {8'hFF, 1'b0, 2'd0, 8'h00, 8'hFF, 8'h00},  // R8 all inputs at once
        {8'hFF, 1'b0, 2'd0, 8'h00, 8'hFF, 8'hFF}   // R3 R8 all inputs overwritten
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; returns at the falling edge after the active edge.
    task automatic step(input logic [7:0] ld, input logic wr, input logic [1:0] a, input logic [7:0] wd);
        @(negedge clk);
        load_stb  = ld;
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = wd;
        @(negedge clk);
        load_stb  = '0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic idle();
        step(8'h00, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_wr   = 1'b0;
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state at reset
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd2, 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1", 2'd1, 8'h00);
        rd("R1", 2'd3, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][34:27], VEC[i][26], VEC[i][25:24], VEC[i][23:16]);
            rd("R2", 2'd0, VEC[i][15:8]);
            rd("R3", 2'd1, VEC[i][7:0]);
        end

        // R7 flags set without enables keep the request low
        idle();
        chk("R7", {7'd0, irq}, 8'h00);

        // R6 R7 completion enable on input 2
        step(8'h00, 1'b1, 2'd2, 8'h04);
        chk("R7", {7'd0, irq}, 8'h00);
        rd("R6", 2'd2, 8'h04);
        idle();
        chk("R7", {7'd0, irq}, 8'h01);

        // R7 acknowledge input 2: request falls one clock later
        step(8'h00, 1'b1, 2'd0, 8'h04);
        chk("R7", {7'd0, irq}, 8'h01);
        idle();
        chk("R7", {7'd0, irq}, 8'h00);

        // R6 R7 overwrite enable on input 7
        step(8'h00, 1'b1, 2'd3, 8'h80);
        rd("R6", 2'd3, 8'h80);
        idle();
        chk("R7", {7'd0, irq}, 8'h01);
        step(8'h00, 1'b1, 2'd1, 8'hFF);
        idle();
        chk("R7", {7'd0, irq}, 8'h00);
        rd("R4", 2'd1, 8'h00);
        step(8'h00, 1'b1, 2'd3, 8'h00);
        rd("R6", 2'd3, 8'h00);

        // R3 reading the flags in between does not prevent an overwrite
        step(8'h00, 1'b1, 2'd0, 8'hFF);
        step(8'h08, 1'b0, 2'd0, 8'h00);
        rd("R3", 2'd0, 8'h08);
        rd("R3", 2'd0, 8'h08);
        step(8'h08, 1'b0, 2'd0, 8'h00);
        rd("R3", 2'd1, 8'h08);

        // R1 reset in the middle of operation
        step(8'h00, 1'b1, 2'd2, 8'hFF);
        idle();
        chk("R1", {7'd0, irq}, 8'h01);
        rst_n = 1'b0;
        #1;
        rd("R1", 2'd0, 8'h00);
        rd("R1", 2'd1, 8'h00);
        rd("R1", 2'd2, 8'h00);
        chk("R1", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule